// File: doc/BRIEF.md
# Scroll Table Address Generator

This block sits in front of a tile-plane renderer. It works out where the scroll offsets for two background planes are stored, fetches them, and hands them back. A caller presents a display line number, a pixel column and the scroll configuration, then pulses `start`. The block captures that request and computes two addresses. The first is the graphics-memory word address of the horizontal-scroll word pair that applies to the line. The second is the vertical-scroll RAM index for each plane.

A small sequencer then runs two reads: first for plane A, then for plane B. Each read presents the horizontal-table word address and the vertical-scroll index for one plane on a single request/acknowledge port. The block latches the returned words, keeping the low 10 bits of the horizontal word and the low 9 bits of the vertical word. It raises `offs_valid` once both planes are held.

The horizontal mode selects which bits of the line number form the pair index. This gives four choices: whole screen, an 8-line repeating pattern, one value per 8-line tile row, or one value per line. With per-strip vertical scroll enabled, the columns are cut into 16-pixel strips and the two planes' words are interleaved per strip.

Top module: `scroll_fetch_gen`

## Requirements
- R1: With `hmode` = 2'b00 the pair index is 0 for every line.
- R2: With `hmode` = 2'b01 the pair index is line[2:0], with all higher bits zero.
- R3: With `hmode` = 2'b10 the pair index is line[7:3] followed by three zero bits.
- R4: With `hmode` = 2'b11 the pair index is the whole line number line[7:0].
- R5: `hs_addr` is hbase*512 + 2*pair, which is the plane-A word; the plane-B word is at `hs_addr`+1. It reflects the request accepted at the previous clock edge.
- R6: With `vstrip_en`=1, `vs_idx_a` = 2*(col>>4) and `vs_idx_b` = 2*(col>>4)+1.
- R7: With `vstrip_en`=0, `vs_idx_a` = 0 and `vs_idx_b` = 1 for every column.
- R8: After an accepted start, the first read has `rd_sel_b`=0, `rd_vram_addr`=`hs_addr` and `rd_vs_idx`=`vs_idx_a`. The request is held until `rd_ack`. The second read has `rd_sel_b`=1, `rd_vram_addr`=`hs_addr`+1 and `rd_vs_idx`=`vs_idx_b`.
- R9: On each acknowledged read, that plane's horizontal offset takes `rd_hword`[9:0] and its vertical offset takes `rd_vword`[8:0]. All upper bits are dropped.
- R10: `offs_valid` rises in the cycle after the plane-B acknowledge. It stays high with unchanged offsets until the next accepted start, which clears it. After reset, `busy`, `rd_req` and `offs_valid` are 0.
- R11: A `start` pulse while `busy` is high is ignored. The captured request and the running fetch are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a fetch for the presented line/column |
| line | input | LINE_W | Display line number |
| col | input | COL_W | Pixel column |
| hmode | input | 2 | Horizontal-scroll table mode |
| vstrip_en | input | 1 | Per-strip vertical scroll enable |
| hbase | input | BASE_W | Horizontal table base in 1 KB units |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_sel_b | output | 1 | Current read is for plane B |
| rd_vram_addr | output | BASE_W+9 | Graphics-memory word address of current read |
| rd_vs_idx | output | COL_W-3 | Vertical-scroll RAM index of current read |
| rd_ack | input | 1 | Read data present this cycle |
| rd_hword | input | DATA_W | Horizontal-table word returned |
| rd_vword | input | DATA_W | Vertical-scroll word returned |
| hs_addr | output | BASE_W+9 | Word address of the pair's plane-A word |
| vs_idx_a | output | COL_W-3 | Vertical-scroll index for plane A |
| vs_idx_b | output | COL_W-3 | Vertical-scroll index for plane B |
| busy | output | 1 | Fetch in progress |
| hoff_a | output | HOFF_W | Latched plane-A horizontal offset |
| hoff_b | output | HOFF_W | Latched plane-B horizontal offset |
| voff_a | output | VOFF_W | Latched plane-A vertical offset |
| voff_b | output | VOFF_W | Latched plane-B vertical offset |
| offs_valid | output | 1 | Both planes' offsets held |

## Verification
The bench builds the block with its default parameters. With LINE_W=8 the bench reaches line 255 and the full 8-bit pair index in the per-line mode. With COL_W=9 it reaches column 511, which is strip 31 and indices 62/63. With BASE_W=6 it reaches base 63, the top of the 15-bit word address space. The memory model returns words whose upper bits are set, so the masking is visible. It also varies the acknowledge delay, so that a request held across wait cycles and back-to-back acknowledges both occur.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
    // Words in one 1 KB step of the table base (log2)
    localparam int KB_WORD_LG2 = 9;
    // Pixels per vertical-scroll strip (log2)
    localparam int STRIP_LG2   = 4;
    // Lines per tile row (log2)
    localparam int ROW_LG2     = 3;

    typedef enum logic [1:0] {
        HS_WHOLE   = 2'b00,
        HS_REPEAT8 = 2'b01,
        HS_TILEROW = 2'b10,
        HS_PERLINE = 2'b11
    } hs_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RD_A = 2'd1,
        SEQ_RD_B = 2'd2
    } seq_state_e;
endpackage

// File: rtl/hscroll_addr.sv
module hscroll_addr
    import scroll_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int BASE_W = 6,
    localparam int AW    = BASE_W + KB_WORD_LG2
) (
    input  logic [LINE_W-1:0] line,
    input  hs_mode_e          mode,
    input  logic [BASE_W-1:0] base,
    output logic [AW-1:0]     addr
);
    localparam logic [LINE_W-1:0] LOW_MASK = LINE_W'((1 << ROW_LG2) - 1);

    logic [LINE_W-1:0] pair;

    always_comb begin
        unique case (mode)
            HS_WHOLE:   pair = '0;
            HS_REPEAT8: pair = line & LOW_MASK;
            HS_TILEROW: pair = line & ~LOW_MASK;
            default:    pair = line;
        endcase
        addr = (AW'(base) << KB_WORD_LG2) | (AW'(pair) << 1);
    end
endmodule

// File: rtl/vscroll_idx.sv
module vscroll_idx
    import scroll_pkg::*;
#(
    parameter int COL_W    = 9,
    localparam int STRIP_W = COL_W - STRIP_LG2,
    localparam int IDX_W   = STRIP_W + 1
) (
    input  logic [COL_W-1:0] col,
    input  logic             strip_en,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_b
);
    logic [STRIP_W-1:0] strip;
    logic [IDX_W-1:0]   idx [2];
    logic               unused_fine;

    assign strip       = col[COL_W-1:STRIP_LG2];
    assign unused_fine = ^col[STRIP_LG2-1:0];

    for (genvar g = 0; g < 2; g++) begin : g_plane
        assign idx[g] = strip_en ? {strip, 1'(g)} : IDX_W'(g);
    end

    assign idx_a = idx[0];
    assign idx_b = idx[1];
endmodule

// File: rtl/scroll_fetch_seq.sv
module scroll_fetch_seq
    import scroll_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HOFF_W = 10,
    parameter int VOFF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_hword,
    input  logic [DATA_W-1:0] rd_vword,
    output logic              rd_req,
    output logic              rd_sel_b,
    output logic              busy,
    output logic [HOFF_W-1:0] hoff_a,
    output logic [HOFF_W-1:0] hoff_b,
    output logic [VOFF_W-1:0] voff_a,
    output logic [VOFF_W-1:0] voff_b,
    output logic              offs_valid
);
    typedef struct packed {
        seq_state_e        state;
        logic [HOFF_W-1:0] hoff_a;
        logic [HOFF_W-1:0] hoff_b;
        logic [VOFF_W-1:0] voff_a;
        logic [VOFF_W-1:0] voff_b;
        logic              valid;
    } seq_t;

    seq_t seq_d, seq_q;
    logic unused_hi;

    assign unused_hi = ^{rd_hword[DATA_W-1:HOFF_W], rd_vword[DATA_W-1:VOFF_W]};

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.state = SEQ_RD_A;
                    seq_d.valid = 1'b0;
                end
            end
            SEQ_RD_A: begin
                if (rd_ack) begin
                    seq_d.hoff_a = rd_hword[HOFF_W-1:0];
                    seq_d.voff_a = rd_vword[VOFF_W-1:0];
                    seq_d.state  = SEQ_RD_B;
                end
            end
            SEQ_RD_B: begin
                if (rd_ack) begin
                    seq_d.hoff_b = rd_hword[HOFF_W-1:0];
                    seq_d.voff_b = rd_vword[VOFF_W-1:0];
                    seq_d.valid  = 1'b1;
                    seq_d.state  = SEQ_IDLE;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy       = (seq_q.state != SEQ_IDLE);
    assign rd_req     = busy;
    assign rd_sel_b   = (seq_q.state == SEQ_RD_B);
    assign hoff_a     = seq_q.hoff_a;
    assign hoff_b     = seq_q.hoff_b;
    assign voff_a     = seq_q.voff_a;
    assign voff_b     = seq_q.voff_b;
    assign offs_valid = seq_q.valid;
endmodule

// File: rtl/scroll_fetch_gen.sv
module scroll_fetch_gen
    import scroll_pkg::*;
#(
    parameter int LINE_W  = 8,
    parameter int COL_W   = 9,
    parameter int BASE_W  = 6,
    parameter int DATA_W  = 16,
    parameter int HOFF_W  = 10,
    parameter int VOFF_W  = 9,
    localparam int AW     = BASE_W + KB_WORD_LG2,
    localparam int VIDX_W = COL_W - STRIP_LG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] line,
    input  logic [COL_W-1:0]  col,
    input  logic [1:0]        hmode,
    input  logic              vstrip_en,
    input  logic [BASE_W-1:0] hbase,
    output logic              rd_req,
    output logic              rd_sel_b,
    output logic [AW-1:0]     rd_vram_addr,
    output logic [VIDX_W-1:0] rd_vs_idx,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_hword,
    input  logic [DATA_W-1:0] rd_vword,
    output logic [AW-1:0]     hs_addr,
    output logic [VIDX_W-1:0] vs_idx_a,
    output logic [VIDX_W-1:0] vs_idx_b,
    output logic              busy,
    output logic [HOFF_W-1:0] hoff_a,
    output logic [HOFF_W-1:0] hoff_b,
    output logic [VOFF_W-1:0] voff_a,
    output logic [VOFF_W-1:0] voff_b,
    output logic              offs_valid
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
        hs_mode_e          mode;
        logic              strip_en;
        logic [BASE_W-1:0] base;
    } req_t;

    req_t req_d, req_q;

    // Capture a request only when the sequencer is free
    always_comb begin
        req_d = req_q;
        if (start && !busy) begin
            req_d.line     = line;
            req_d.col      = col;
            req_d.mode     = hs_mode_e'(hmode);
            req_d.strip_en = vstrip_en;
            req_d.base     = hbase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '{mode: HS_WHOLE, default: '0};
        end else begin
            req_q <= req_d;
        end
    end

    hscroll_addr #(
        .LINE_W (LINE_W),
        .BASE_W (BASE_W)
    ) u_haddr (
        .line (req_q.line),
        .mode (req_q.mode),
        .base (req_q.base),
        .addr (hs_addr)
    );

    vscroll_idx #(
        .COL_W (COL_W)
    ) u_vidx (
        .col      (req_q.col),
        .strip_en (req_q.strip_en),
        .idx_a    (vs_idx_a),
        .idx_b    (vs_idx_b)
    );

    scroll_fetch_seq #(
        .DATA_W (DATA_W),
        .HOFF_W (HOFF_W),
        .VOFF_W (VOFF_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rd_ack     (rd_ack),
        .rd_hword   (rd_hword),
        .rd_vword   (rd_vword),
        .rd_req     (rd_req),
        .rd_sel_b   (rd_sel_b),
        .busy       (busy),
        .hoff_a     (hoff_a),
        .hoff_b     (hoff_b),
        .voff_a     (voff_a),
        .voff_b     (voff_b),
        .offs_valid (offs_valid)
    );

    // Plane B's horizontal word is the odd word of the pair
    assign rd_vram_addr = hs_addr | AW'(rd_sel_b);
    assign rd_vs_idx    = rd_sel_b ? vs_idx_b : vs_idx_a;
endmodule

// File: rtl/scroll_fetch_chk.sv
module scroll_fetch_chk #(
    parameter int AW     = 15,
    parameter int VIDX_W = 6,
    parameter int HOFF_W = 10,
    parameter int VOFF_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              rd_sel_b,
    input logic [AW-1:0]     rd_vram_addr,
    input logic [AW-1:0]     hs_addr,
    input logic [VIDX_W-1:0] vs_idx_a,
    input logic [VIDX_W-1:0] vs_idx_b,
    input logic              offs_valid,
    input logic [HOFF_W-1:0] hoff_a,
    input logic [VOFF_W-1:0] voff_a
);
    // R8
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && !rd_sel_b) |=> (rd_req && rd_sel_b));

    // R8
    plane_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_vram_addr[0] == rd_sel_b));

    // R6
    vs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_idx_b == vs_idx_a + VIDX_W'(1)) && !vs_idx_a[0]);

    // R5
    hs_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_addr[0]);

    // R10
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(offs_valid) |-> $past(rd_req && rd_ack && rd_sel_b));

    // R10
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offs_valid && $past(offs_valid)) |-> ($stable(hoff_a) && $stable(voff_a)));

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offs_valid |-> !busy);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(hs_addr));
endmodule

bind scroll_fetch_gen scroll_fetch_chk #(
    .AW     (AW),
    .VIDX_W (VIDX_W),
    .HOFF_W (HOFF_W),
    .VOFF_W (VOFF_W)
) u_chk (.*);

// File: tb/test_scroll_fetch_gen.sv
`timescale 1ns/1ps
module test_scroll_fetch_gen;
    localparam int AW     = 15;
    localparam int VIDX_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  line = '0;
    logic [8:0]  col = '0;
    logic [1:0]  hmode = '0;
    logic        vstrip_en = 1'b0;
    logic [5:0]  hbase = '0;
    logic        rd_req, rd_sel_b;
    logic [AW-1:0]     rd_vram_addr, hs_addr;
    logic [VIDX_W-1:0] rd_vs_idx, vs_idx_a, vs_idx_b;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_hword = '0, rd_vword = '0;
    logic        busy, offs_valid;
    logic [9:0]  hoff_a, hoff_b;
    logic [8:0]  voff_a, voff_b;

    scroll_fetch_gen i_scroll_fetch_gen (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        logic [AW-1:0]     haddr;
        logic [VIDX_W-1:0] va, vb;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] hmem(input logic [AW-1:0] a);
        return {a[7:0], a[14:7]} ^ 16'hC35A;
    endfunction

    function automatic logic [15:0] vmem(input logic [VIDX_W-1:0] i);
        return {i, 10'h2D5} ^ 16'h9100;
    endfunction

    function automatic exp_t model(input logic [7:0] y, input logic [8:0] c,
                                   input logic [1:0] m, input logic ven,
                                   input logic [5:0] b);
        exp_t e;
        logic [7:0] pair;
        case (m)
            2'b00:   begin pair = 8'd0;              e.tag = "R1"; end
            2'b01:   begin pair = {5'd0, y[2:0]};    e.tag = "R2"; end
            2'b10:   begin pair = {y[7:3], 3'd0};    e.tag = "R3"; end
            default: begin pair = y;                 e.tag = "R4"; end
        endcase
        e.haddr = AW'(b) * 512 + AW'(pair) * 2;
        if (ven) begin
            e.va = VIDX_W'(c / 16) * 2;
            e.vb = VIDX_W'(c / 16) * 2 + 1;
        end else begin
            e.va = 0;
            e.vb = 1;
        end
        return e;
    endfunction

    // Driver: waits for an idle block, issues one request, pushes the expectation
    task automatic fetch(input logic [7:0] y, input logic [8:0] c, input logic [1:0] m,
                         input logic ven, input logic [5:0] b, input bit poke_busy);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e = model(y, c, m, ven, b);
        line = y; col = c; hmode = m; vstrip_en = ven; hbase = b;
        start = 1'b1;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R11: a request while busy must change nothing
            line = ~y; col = ~c; hmode = ~m; vstrip_en = ~ven; hbase = ~b;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(hs_addr == e.haddr, "R11", "hs_addr after ignored start", 32'(hs_addr), 32'(e.haddr));
            chk(vs_idx_a == e.va, "R11", "vs_idx_a after ignored start", 32'(vs_idx_a), 32'(e.va));
        end
    endtask

    // Memory responder: acknowledges with varying delay, checks the read address
    int  wait_left = 0;
    int  wait_sel  = 0;
    bit  step_b    = 1'b0;
    always @(negedge clk) begin
        rd_ack <= 1'b0;
        if (rst_n && rd_req) begin
            if (wait_left > 0) begin
                wait_left--;
            end else if (q.size() == 0) begin
                chk(1'b0, "R8", "read with no request pending", 32'(rd_vram_addr), 32'hFFFF);
            end else begin
                // R8: plane A first, then plane B
                logic [AW-1:0]     ea;
                logic [VIDX_W-1:0] ei;
                ea = step_b ? q[0].haddr + 1 : q[0].haddr;
                ei = step_b ? q[0].vb : q[0].va;
                chk(rd_sel_b == step_b, "R8", "rd_sel_b", 32'(rd_sel_b), 32'(step_b));
                chk(rd_vram_addr == ea, q[0].tag, "rd_vram_addr (R5)", 32'(rd_vram_addr), 32'(ea));
                chk(rd_vs_idx == ei, q[0].va == 0 && q[0].vb == 1 ? "R7" : "R6",
                    "rd_vs_idx", 32'(rd_vs_idx), 32'(ei));
                rd_ack   <= 1'b1;
                rd_hword <= hmem(ea);
                rd_vword <= vmem(ei);
                step_b   = ~step_b;
                wait_sel = (wait_sel + 1) % 4;
                wait_left = (wait_sel == 3) ? 2 : (wait_sel == 1 ? 1 : 0);
            end
        end
    end

    // Monitor: on each rise of offs_valid, pop and compare
    bit prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst_n && offs_valid && !prev_v) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10", "valid with nothing expected", 32'(offs_valid), 32'h0);
            end else begin
                exp_t e;
                logic [9:0] eha, ehb;
                logic [8:0] eva, evb;
                e = q.pop_front();
                eha = hmem(e.haddr)[9:0];
                ehb = hmem(e.haddr + 1)[9:0];
                eva = vmem(e.va)[8:0];
                evb = vmem(e.vb)[8:0];
                chk(hs_addr == e.haddr, e.tag, "hs_addr (R5)", 32'(hs_addr), 32'(e.haddr));
                chk(vs_idx_a == e.va && vs_idx_b == e.vb, e.va == 0 && e.vb == 1 ? "R7" : "R6",
                    "vs_idx pair", {16'(vs_idx_a), 16'(vs_idx_b)}, {16'(e.va), 16'(e.vb)});
                chk(hoff_a == eha, "R9", "hoff_a", 32'(hoff_a), 32'(eha));
                chk(hoff_b == ehb, "R9", "hoff_b", 32'(hoff_b), 32'(ehb));
                chk(voff_a == eva, "R9", "voff_a", 32'(voff_a), 32'(eva));
                chk(voff_b == evb, "R9", "voff_b", 32'(voff_b), 32'(evb));
                chk(!busy, "R10", "busy with valid", 32'(busy), 32'h0);
            end
        end
        prev_v = offs_valid;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "R10", "watchdog expired", 32'(cycles), 32'd100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !rd_req && !offs_valid, "R10", "reset busy/req/valid",
            {29'd0, busy, rd_req, offs_valid}, 32'h0);
        chk(hoff_a == 0 && voff_b == 0, "R10", "reset offsets", {hoff_a, 13'd0, voff_b}, 32'h0);
        rst_n = 1'b1;

        // R1 whole screen
        fetch(8'd0,   9'd0,   2'b00, 1'b0, 6'd0,  1'b0);
        fetch(8'd201, 9'd300, 2'b00, 1'b1, 6'd5,  1'b0);
        // R2 repeating 8-line pattern
        fetch(8'd7,   9'd15,  2'b01, 1'b1, 6'd1,  1'b0);
        fetch(8'd253, 9'd16,  2'b01, 1'b0, 6'd63, 1'b0);
        // R3 per tile row
        fetch(8'd13,  9'd319, 2'b10, 1'b1, 6'd2,  1'b0);
        fetch(8'd255, 9'd511, 2'b10, 1'b1, 6'd63, 1'b0);
        // R4 per line
        fetch(8'd8,   9'd32,  2'b11, 1'b0, 6'd0,  1'b0);
        fetch(8'd255, 9'd511, 2'b11, 1'b1, 6'd63, 1'b0);
        fetch(8'd170, 9'd255, 2'b11, 1'b1, 6'd42, 1'b0);
        // R11 start during busy
        fetch(8'd99,  9'd77,  2'b11, 1'b1, 6'd17, 1'b1);
        fetch(8'd44,  9'd400, 2'b10, 1'b0, 6'd9,  1'b1);
        // sweep of columns and lines
        for (int i = 0; i < 24; i++) begin
            fetch(8'(i * 37 + 3), 9'(i * 23), 2'(i), 1'(i / 4), 6'(i * 11), 1'b0);
        end

        @(negedge clk);
        while (busy || q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        // R10: valid holds while idle
        chk(offs_valid, "R10", "valid held while idle", 32'(offs_valid), 32'h1);
        chk(q.size() == 0, "R11", "queue drained", 32'(q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule